// File: doc/BRIEF.md
# DRAM Refresh and Access Sequencer

This block drives the row strobes, column strobes, write enable and multiplexed address of a bank of DRAM rows. Each row has its own RAS line. A host asks for a four-beat burst on a request/grant port. The block opens the selected row, steps through four column addresses and precharges. It reports each transferred beat on a one-cycle acknowledge. Writes are posted: the host is acknowledged on a fixed 4-1-1-1 schedule, and the DRAM side finishes the write at its own pace before another grant can be issued.

Refresh is paced by a free-running internal timer, with no outside refresh source. Each timer tick adds one to a small pending count. Two configuration bits choose the refresh method and the issue pattern. The method is either CAS-before-RAS, or RAS-only with a row address taken from an internal refresh counter. The pattern is either one refresh per tick or back-to-back groups of four. A speed bit selects one of two timing sets, suited to faster or slower DRAM.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and right after it, every RAS and CAS line and we_n are high, and gnt and ack are low.
- R2: An accepted request raises gnt for exactly one cycle. In that cycle only the RAS line numbered req_row is low, and ma holds req_addr's upper MA_W bits (the row address). At most one RAS line is low at any time outside refresh.
- R3: A host access makes four CAS-low beats. In beat k, ma holds the lower MA_W bits of req_addr plus k, wrapping modulo 2^MA_W. During a write's CAS-low cycles we_n is low; during a read's it is high.
- R4: Read timing per speed bit. With cfg_fast=1 the row-to-column delay is 2 cycles, CAS-low is 1, CAS-high is 1 and precharge is 3. With cfg_fast=0 these are 3, 2, 1 and 4. A read acknowledges in the last CAS-low cycle of each beat, counting the gnt cycle as cycle 0.
- R5: A write acknowledges in four consecutive cycles starting two cycles after the gnt cycle. This is 4-1-1-1 counting the request cycle as the first, and is independent of the speed bit.
- R6: A refresh tick occurs every REF_PERIOD clocks from the internal timer. With one refresh per tick and no host traffic, consecutive refreshes start exactly REF_PERIOD cycles apart.
- R7: With cfg_cbr=1, all CAS lines go low one cycle before all RAS lines go low, while all RAS lines are still high. All RAS lines stay low for 4 cycles (cfg_fast=1) or 5 cycles (cfg_fast=0), then everything stays high for the precharge time.
- R8: With cfg_cbr=0, a refresh drives all RAS lines low with all CAS lines high. ma holds the refresh row counter, which is 0 after reset and advances by one after each refresh of either method.
- R9: With cfg_burst4=0, every tick yields one refresh. A pending refresh wins over a host request, so refresh keeps its rate under a continuous stream of requests.
- R10: With cfg_burst4=1, refreshes come in back-to-back groups of four. A group starts once four ticks are pending, or earlier if at least one is pending and no host request is present.
- R11: A grant is given only in a cycle that follows a cycle with all RAS lines high, so a running refresh or access always completes first. No acknowledge occurs while all RAS lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cbr | input | 1 | 1: CAS-before-RAS refresh, 0: RAS-only refresh |
| cfg_burst4 | input | 1 | 1: refresh in groups of four, 0: one per tick |
| cfg_fast | input | 1 | 1: faster DRAM timing set, 0: slower set |
| req | input | 1 | Host request, held until gnt |
| req_we | input | 1 | 1: write burst, 0: read burst |
| req_row | input | $clog2(ROWS) | Index of the DRAM row to access |
| req_addr | input | 2*MA_W | Row address (upper half) and starting column (lower half) |
| gnt | output | 1 | One-cycle grant of the request |
| ack | output | 1 | One-cycle acknowledge of a data beat |
| ras_n | output | ROWS | Active-low row strobes, one per row |
| cas_n | output | CAS_LANES | Active-low column strobes |
| we_n | output | 1 | Active-low write enable |
| ma | output | MA_W | Multiplexed DRAM address |

## Verification
The cycle-by-cycle checks cover strobe-level invariants. At most one row is open outside refresh. CAS-before-RAS and RAS-only refresh each keep their strobe order. A grant follows an all-precharged cycle, gnt lasts one cycle, and no beat is acknowledged during refresh. The bench scenarios cover behaviour that spans many cycles or depends on configuration. That includes acknowledge positions for each speed and direction, column stepping with wrap, the refresh row counter's progression, and the tick spacing. It also covers the grouping of refreshes into singles or fours, and refresh still winning under a saturating stream of host requests.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int ROWS       = 8,
  parameter int MA_W       = 10,
  parameter int CAS_LANES  = 4,
  parameter int REF_PERIOD = 390,
  parameter int RCD_FAST   = 2,
  parameter int RCD_SLOW   = 3,
  parameter int CASL_FAST  = 1,
  parameter int CASL_SLOW  = 2,
  parameter int RP_FAST    = 3,
  parameter int RP_SLOW    = 4,
  parameter int RASR_FAST  = 4,
  parameter int RASR_SLOW  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_cbr,
  input  logic                     cfg_burst4,
  input  logic                     cfg_fast,
  input  logic                     req,
  input  logic                     req_we,
  input  logic [$clog2(ROWS)-1:0]  req_row,
  input  logic [2*MA_W-1:0]        req_addr,
  output logic                     gnt,
  output logic                     ack,
  output logic [ROWS-1:0]          ras_n,
  output logic [CAS_LANES-1:0]     cas_n,
  output logic                     we_n,
  output logic [MA_W-1:0]          ma
);
  localparam int RS_W = $clog2(ROWS);
  localparam int TW   = $clog2(RCD_SLOW + CASL_SLOW + RP_SLOW + RASR_SLOW +
                               RCD_FAST + CASL_FAST + RP_FAST + RASR_FAST + 1);
  localparam int RT_W = $clog2(REF_PERIOD);

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_CLO, S_CHI, S_PRE, S_RCAS, S_RRAS, S_RPRE
  } st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [1:0]       beat, left;
  logic [2:0]       pend, take, pend_nx, wcnt;
  logic [3:0]       psum;
  logic [RT_W-1:0]  rt;
  logic [MA_W-1:0]  refa, rowa_l, col_l;
  logic [RS_W-1:0]  row_l;
  logic             wr_l, tick, ref_go, acc_go, host_open, in_ref;
  logic [TW-1:0]    t_rcd, t_cl, t_rp, t_ras;

  assign t_rcd = cfg_fast ? TW'(RCD_FAST - 1)  : TW'(RCD_SLOW - 1);
  assign t_cl  = cfg_fast ? TW'(CASL_FAST - 1) : TW'(CASL_SLOW - 1);
  assign t_rp  = cfg_fast ? TW'(RP_FAST - 1)   : TW'(RP_SLOW - 1);
  assign t_ras = cfg_fast ? TW'(RASR_FAST - 1) : TW'(RASR_SLOW - 1);

  assign tick   = (rt == RT_W'(REF_PERIOD - 1));
  assign ref_go = (st == S_IDLE) && (pend != 3'd0) &&
                  (!cfg_burst4 || pend >= 3'd4 || !req);
  assign acc_go = (st == S_IDLE) && !ref_go && req;

  assign take    = !ref_go ? 3'd0 : !cfg_burst4 ? 3'd1 : (pend > 3'd4 ? 3'd4 : pend);
  assign psum    = {1'b0, pend} - {1'b0, take} + {3'b000, tick};
  assign pend_nx = psum[3] ? 3'd7 : psum[2:0];

  assign host_open = (st == S_ACT) || (st == S_CLO) || (st == S_CHI);
  assign in_ref    = (st == S_RCAS) || (st == S_RRAS) || (st == S_RPRE);

  assign ras_n = (st == S_RRAS) ? '0 :
                 host_open      ? ~(ROWS'(1) << row_l) : '1;
  assign cas_n = ((st == S_CLO) || (st == S_RCAS) || (st == S_RRAS && cfg_cbr)) ? '0 : '1;
  assign we_n  = !((st == S_CLO) && wr_l);
  assign ma    = ((st == S_CLO) || (st == S_CHI)) ? col_l + MA_W'(beat) :
                 in_ref ? refa : rowa_l;
  assign ack   = wr_l ? (wcnt >= 3'd3) : ((st == S_CLO) && (tmr == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      beat   <= '0;
      left   <= '0;
      pend   <= '0;
      rt     <= '0;
      refa   <= '0;
      row_l  <= '0;
      rowa_l <= '0;
      col_l  <= '0;
      wr_l   <= 1'b0;
      wcnt   <= '0;
      gnt    <= 1'b0;
    end else begin
      gnt  <= acc_go;
      rt   <= tick ? '0 : rt + 1'b1;
      pend <= pend_nx;
      if (acc_go)
        wcnt <= req_we ? 3'd1 : 3'd0;
      else if (wcnt != 3'd0)
        wcnt <= (wcnt == 3'd6) ? 3'd0 : wcnt + 3'd1;

      case (st)
        S_IDLE: begin
          if (ref_go) begin
            left <= cfg_burst4 ? 2'd3 : 2'd0;
            st   <= cfg_cbr ? S_RCAS : S_RRAS;
            tmr  <= cfg_cbr ? '0 : t_ras;
          end else if (req) begin
            row_l  <= req_row;
            rowa_l <= req_addr[2*MA_W-1:MA_W];
            col_l  <= req_addr[MA_W-1:0];
            wr_l   <= req_we;
            st     <= S_ACT;
            tmr    <= t_rcd;
          end
        end
        S_ACT: begin
          if (tmr == '0) begin
            st   <= S_CLO;
            tmr  <= t_cl;
            beat <= 2'd0;
          end else tmr <= tmr - 1'b1;
        end
        S_CLO: begin
          if (tmr == '0) st <= S_CHI;
          else tmr <= tmr - 1'b1;
        end
        S_CHI: begin
          if (beat == 2'd3) begin
            st  <= S_PRE;
            tmr <= t_rp;
          end else begin
            beat <= beat + 2'd1;
            st   <= S_CLO;
            tmr  <= t_cl;
          end
        end
        S_PRE: begin
          if (tmr == '0) st <= S_IDLE;
          else tmr <= tmr - 1'b1;
        end
        S_RCAS: begin
          st  <= S_RRAS;
          tmr <= t_ras;
        end
        S_RRAS: begin
          if (tmr == '0) begin
            st  <= S_RPRE;
            tmr <= t_rp;
          end else tmr <= tmr - 1'b1;
        end
        S_RPRE: begin
          if (tmr == '0) begin
            refa <= refa + 1'b1;
            if (left != 2'd0) begin
              left <= left - 2'd1;
              st   <= cfg_cbr ? S_RCAS : S_RRAS;
              tmr  <= cfg_cbr ? '0 : t_ras;
            end else st <= S_IDLE;
          end else tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int ROWS      = 8,
  parameter int CAS_LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_cbr,
  input logic [ROWS-1:0]      ras_n,
  input logic [CAS_LANES-1:0] cas_n,
  input logic                 gnt,
  input logic                 ack
);
  assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~ras_n) <= 1) || (ras_n == '0));

  assert_gnt_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |=> !gnt);

  assert_cbr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cbr && ras_n == '0 && $past(ras_n) != '0) |-> ($past(cas_n) == '0 && $past(ras_n) == '1));

  assert_rasonly_cas_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_cbr && ras_n == '0) |-> (cas_n == '1));

  assert_gnt_after_precharge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> ($past(ras_n) == '1));

  assert_no_ack_in_refresh_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0) |-> !ack);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.ROWS(ROWS), .CAS_LANES(CAS_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cbr(cfg_cbr), .ras_n(ras_n),
  .cas_n(cas_n), .gnt(gnt), .ack(ack)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int ROWS = 8, MA_W = 10, CL = 4, PER = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c_cbr = 0, c_burst = 0, c_fast = 1, req = 0, req_we = 0;
  logic [2:0] req_row = '0;
  logic [2*MA_W-1:0] req_addr = '0;
  logic gnt, ack, we_n;
  logic [ROWS-1:0] ras_n;
  logic [CL-1:0] cas_n;
  logic [MA_W-1:0] ma;

  always #10 clk = ~clk;

  dram_refresh_seq #(.ROWS(ROWS), .MA_W(MA_W), .CAS_LANES(CL), .REF_PERIOD(PER)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_cbr(c_cbr), .cfg_burst4(c_burst), .cfg_fast(c_fast),
    .req(req), .req_we(req_we), .req_row(req_row), .req_addr(req_addr),
    .gnt(gnt), .ack(ack), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ma(ma));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string r, input string what, input int a, input int e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, a, e);
    end
  endtask

  function automatic int exp_off(input bit we, input bit fast, input int k);
    int rcd = fast ? 2 : 3;
    int cl  = fast ? 1 : 2;
    if (we) return 2 + k;
    return rcd + cl - 1 + k * (cl + 1);
  endfunction

  function automatic int tras(input bit fast); return fast ? 4 : 5; endfunction
  function automatic int reflen(input bit cbr, input bit fast);
    return tras(fast) + (fast ? 3 : 4) + (cbr ? 1 : 0);
  endfunction

  // values for the next grant, captured by the monitor when gnt appears
  logic [2:0] nxt_row; logic [MA_W-1:0] nxt_rowa, nxt_col; logic nxt_we;
  logic [2:0] exp_row; logic [MA_W-1:0] exp_rowa, exp_col; logic exp_we;
  logic [MA_W-1:0] exp_ra;
  logic [ROWS-1:0] pras; logic [CL-1:0] pcas;
  int gcyc, off, nack, nbeat, lowcnt, last_start, run, nref;
  bit act, have_start, chk_period;

  always @(negedge clk) begin
    if (!rst_n) begin
      gcyc = 0; act = 0; have_start = 0; run = 0; nref = 0; lowcnt = 0;
      exp_ra = '0; pras = '1; pcas = '1; last_start = 0;
    end else begin
      gcyc++;
      if (gnt) begin
        exp_row = nxt_row; exp_rowa = nxt_rowa; exp_col = nxt_col; exp_we = nxt_we;
        chk(ras_n == ~(ROWS'(1) << exp_row), "R2", "ras_n at grant", int'(ras_n), int'(~(ROWS'(1) << exp_row)));
        chk(ma == exp_rowa, "R2", "row address at grant", int'(ma), int'(exp_rowa));
        chk(pras == '1, "R11", "ras_n before grant", int'(pras), (1 << ROWS) - 1);
        act = 1; off = 0; nack = 0; nbeat = 0;
      end
      if (ack) begin
        chk(ras_n != '0, "R11", "ack during refresh", int'(ras_n), 1);
        if (act) begin
          if (exp_we) chk(off == exp_off(1, c_fast, nack), "R5", "write ack offset", off, exp_off(1, c_fast, nack));
          else        chk(off == exp_off(0, c_fast, nack), "R4", "read ack offset", off, exp_off(0, c_fast, nack));
        end
        nack++;
      end
      if (act && cas_n == '0 && ras_n != '0) begin
        chk(ma == exp_col + MA_W'(nbeat), "R3", "column address", int'(ma), int'(exp_col + MA_W'(nbeat)));
        chk(we_n == !exp_we, "R3", "we_n in beat", int'(we_n), int'(!exp_we));
      end
      if (act && pcas == '0 && cas_n == '1) nbeat++;
      if (act && !gnt && ras_n == '1) begin
        chk(nack == 4, exp_we ? "R5" : "R4", "acks per burst", nack, 4);
        chk(nbeat == 4, "R3", "beats per burst", nbeat, 4);
        act = 0;
      end
      if (act) off++;
      if (ras_n == '0 && pras != '0) begin
        if (c_cbr) chk(pcas == '0 && pras == '1, "R7", "cas before ras", int'(pcas), 0);
        else begin
          chk(cas_n == '1, "R8", "cas high in ras-only", int'(cas_n), (1 << CL) - 1);
          chk(ma == exp_ra, "R8", "refresh row", int'(ma), int'(exp_ra));
        end
        if (chk_period && have_start) chk(gcyc - last_start == PER, "R6", "refresh spacing", gcyc - last_start, PER);
        if (have_start && gcyc - last_start == reflen(c_cbr, c_fast)) run++;
        else begin
          if (have_start) chk(run == (c_burst ? 4 : 1), c_burst ? "R10" : "R9", "refresh group size", run, c_burst ? 4 : 1);
          run = 1;
        end
        exp_ra++; last_start = gcyc; have_start = 1; nref++; lowcnt = 0;
      end
      if (ras_n == '0) lowcnt++;
      if (ras_n != '0 && pras == '0)
        chk(lowcnt == tras(c_fast), c_cbr ? "R7" : "R8", "refresh ras low cycles", lowcnt, tras(c_fast));
      pras = ras_n; pcas = cas_n;
    end
  end

  task automatic do_reset(input bit cbr, input bit burst, input bit fast);
    @(negedge clk);
    rst_n = 0; req = 0; c_cbr = cbr; c_burst = burst; c_fast = fast; chk_period = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic do_access(input logic [2:0] row, input logic [2*MA_W-1:0] addr, input bit we);
    @(negedge clk);
    nxt_row = row; nxt_rowa = addr[2*MA_W-1:MA_W]; nxt_col = addr[MA_W-1:0]; nxt_we = we;
    req_row = row; req_addr = addr; req_we = we; req = 1;
    do @(negedge clk); while (!gnt);
    req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int rs;
    rs = $urandom(32'd4093);
    rst_n = 0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(ras_n == '1, "R1", "ras_n in reset", int'(ras_n), (1 << ROWS) - 1);
    chk(cas_n == '1, "R1", "cas_n in reset", int'(cas_n), (1 << CL) - 1);
    chk(!gnt && !ack, "R1", "gnt/ack in reset", int'({gnt, ack}), 0);
    chk(we_n, "R1", "we_n in reset", int'(we_n), 1);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n == '1 && cas_n == '1 && !gnt && !ack, "R1", "outputs after reset", int'(ras_n), (1 << ROWS) - 1);

    // R6, R8: single RAS-only refresh, idle bus
    do_reset(0, 0, 1);
    chk_period = 1;
    idle(8 * PER);
    chk(nref >= 7, "R6", "refresh count idle", nref, 7);

    // R7: single CAS-before-RAS, slow timing
    do_reset(1, 0, 0);
    chk_period = 1;
    idle(6 * PER);

    // R2..R5 directed, fast then slow; R3 column wrap
    do_reset(1, 0, 1);
    do_access(3'd0, {10'h3FF, 10'h3FE}, 0);
    do_access(3'd7, {10'h015, 10'h3FF}, 1);
    do_access(3'd4, {10'h100, 10'h000}, 0);
    idle(30);
    do_reset(0, 0, 0);
    do_access(3'd2, {10'h2AA, 10'h3FD}, 0);
    do_access(3'd5, {10'h055, 10'h010}, 1);
    do_access(3'd1, {10'h001, 10'h1FF}, 1);
    idle(30);

    // R9: single mode under continuous requests
    do_reset(0, 0, 1);
    while (gcyc < 20 * PER)
      do_access(3'($urandom % ROWS), 20'($urandom), 1'($urandom % 2));
    chk(nref >= 18, "R9", "refreshes under host load", nref, 18);

    // R10: groups of four, host saturating then idle
    do_reset(1, 1, 1);
    while (gcyc < 14 * PER)
      do_access(3'($urandom % ROWS), 20'($urandom), 1'($urandom % 2));
    chk(nref >= 8, "R10", "burst refreshes under load", nref, 8);
    do_reset(0, 1, 0);
    idle(9 * PER);
    chk(nref >= 28, "R10", "burst refreshes idle", nref, 28);

    // constrained random segments
    for (int s = 0; s < 4; s++) begin
      do_reset(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      for (int i = 0; i < 70; i++) begin
        do_access(3'($urandom % ROWS), 20'($urandom), 1'($urandom % 2));
        idle($urandom % 7);
      end
      idle(40);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog: actual %0d cycles expected completion before %0d", 150000, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule